// File: doc/BRIEF.md
# Linked-List Transmit DMA Engine

This block moves outgoing packets from system memory to a byte stream without help from software once started. Software places a chain of descriptors in memory. Each descriptor is three 32-bit little-endian words at consecutive word addresses: the packet buffer address at offset 0, a size/flags word at offset 4, and the address of the next descriptor at offset 8. The engine reads a descriptor and, if the descriptor holds a packet, reads the packet buffer one word at a time. It sends the bytes out least significant byte first, writes the descriptor back marked as consumed, and then follows the next pointer.

The walk begins when software writes 1 to the enable bit while the MAC transmit-enable input is high. It ends at the first descriptor whose empty flag is already set. At that point the engine raises a one-cycle underrun event and clears the enable bit on its own. Each consumed descriptor produces a one-cycle sent event for a separate status block. When the loopback input is high at the start of a walk, that walk's frames go to the local receive port and not to the transmit port.

The memory port allows one request at a time. The address, write flag and write data stay held with the request until a grant arrives. For a read, the data is valid in the grant cycle. Packet buffers are assumed to be word aligned.

Top module: `tdma_engine`

## Requirements
- R1: After reset the outputs are as follows: busy, dma_en, mem_req, tx_valid, lb_valid, sent_evt and underrun_evt are all low.
- R2: A walk starts only when en_wr is pulsed with en_wdata=1 while mac_tx_en is high. If mac_tx_en is low, the write only stores the bit in dma_en. No memory request is made and busy stays low.
- R3: The base address register forces bits 1:0 to zero, so the first descriptor read goes to the aligned address.
- R4: A descriptor at address D is fetched as three reads at D, D+4 and D+8. In the word at D+4, bit 31 is the empty flag and bits 10:0 are the packet length. A pending request keeps its address and direction stable until it is granted.
- R5: A descriptor with the empty flag set ends the walk. underrun_evt pulses for one cycle, dma_en returns to 0 and busy falls in the same cycle. No bytes are sent and no write-back is made for that descriptor.
- R6: Packet bytes come from the words at buf, buf+4, and so on, taking byte lanes 7:0 first and 31:24 last. The first byte carries sop and the last byte carries eop.
- R7: Exactly length bytes are sent. Byte lanes past the length in the final word are never emitted.
- R8: After a packet, the engine makes three writes at D, D+4 and D+8. They carry the buffer address unchanged, the size/flags word with bit 31 set, and the next pointer.
- R9: sent_evt pulses once for each packet, in the cycle after the last write-back is granted. The next descriptor fetch then goes to the next pointer.
- R10: With loop_en high at the start of a walk, every byte of that walk appears on the lb_* port and tx_valid stays low.
- R11: While busy, any en_wr (value 0 or 1) is ignored: dma_en stays 1 and the walk continues without restarting.
- R12: While a byte is valid but not accepted by ready, the byte and its markers hold stable.
- R13: A length of 0 sends no bytes but is still written back as consumed and counted by sent_evt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| base_wr | input | 1 | Write strobe for the first-descriptor address |
| base_wdata | input | ADDR_W | First-descriptor address (bits 1:0 dropped) |
| en_wr | input | 1 | Write strobe for the enable bit |
| en_wdata | input | 1 | Value written to the enable bit |
| mac_tx_en | input | 1 | MAC transmit enable, required to start |
| loop_en | input | 1 | Route frames to the receive port |
| dma_en | output | 1 | Current enable bit |
| busy | output | 1 | Chain walk in progress |
| sent_evt | output | 1 | One-cycle packet-consumed event |
| underrun_evt | output | 1 | One-cycle end-of-chain event |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Request accepted; read data valid |
| mem_rdata | input | 32 | Read data |
| tx_valid | output | 1 | Transmit byte valid |
| tx_data | output | 8 | Transmit byte |
| tx_sop | output | 1 | First byte of a packet |
| tx_eop | output | 1 | Last byte of a packet |
| tx_ready | input | 1 | Transmit sink ready |
| lb_valid | output | 1 | Loopback byte valid |
| lb_data | output | 8 | Loopback byte |
| lb_sop | output | 1 | First byte of a looped packet |
| lb_eop | output | 1 | Last byte of a looped packet |
| lb_ready | input | 1 | Loopback sink ready |

## Verification
The bench fills its final partial words with a filler byte. An engine that ignores the length then leaks filler bytes or loses the eop position. A chain ends with a zero-length entry, which exposes an engine that skips the write-back or hangs when it has no bytes to send. Slow grants combined with stalled ready catch byte lanes that advance without a handshake. Enable writes issued mid-walk catch a design that restarts from the base and produces extra sent or underrun events. A chain whose first entry is empty must give an underrun with no write-back, which catches a design that sends a stale packet.

// File: rtl/tdma_pkg.sv
// Shared constants and state encoding for the transmit DMA engine.
// Assumes 32-bit descriptor words; other widths come from module parameters.
package tdma_pkg;
    localparam int WORD_W    = 32;
    localparam int EMPTY_BIT = 31;
    localparam int DESC_WORDS = 3;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_D0,
        ST_D1,
        ST_D2,
        ST_CHK,
        ST_RD,
        ST_TX,
        ST_W0,
        ST_W1,
        ST_W2
    } tdma_state_e;
endpackage

// File: rtl/tdma_byte_ser.sv
// Word-to-byte serializer: takes one word with a byte count and emits the
// bytes lowest lane first on a valid/ready handshake.
// Assumes load is asserted only while idle is high.
module tdma_byte_ser #(
    parameter int WORD_W = 32,
    parameter int NB_W   = $clog2(WORD_W / 8) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] load_word,
    input  logic [NB_W-1:0]   load_nb,
    input  logic              load_first,
    input  logic              load_last,
    output logic              out_valid,
    output logic [7:0]        out_data,
    output logic              out_sop,
    output logic              out_eop,
    input  logic              out_ready,
    output logic              idle
);
    logic [WORD_W-1:0] sh_q;
    logic [NB_W-1:0]   cnt_q;
    logic              first_q;
    logic              last_q;

    // Shift register: load a word, then drop one byte per accepted beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q    <= '0;
            cnt_q   <= '0;
            first_q <= 1'b0;
            last_q  <= 1'b0;
        end else if (load) begin
            sh_q    <= load_word;
            cnt_q   <= load_nb;
            first_q <= load_first;
            last_q  <= load_last;
        end else if (out_valid && out_ready) begin
            sh_q    <= sh_q >> 8;
            cnt_q   <= cnt_q - 1'b1;
            first_q <= 1'b0;
        end
    end

    // Output view of the lowest remaining lane.
    always_comb begin
        out_valid = (cnt_q != '0);
        out_data  = sh_q[7:0];
        out_sop   = first_q;
        out_eop   = last_q && (cnt_q == NB_W'(1));
        idle      = (cnt_q == '0);
    end

    // R12: a stalled beat keeps its byte and markers.
    a_r12_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data)
                                    && $stable(out_sop) && $stable(out_eop));
endmodule

// File: rtl/tdma_route.sv
// Output steering: sends the byte stream to the transmit or the loopback
// port, chosen per walk. Assumes sel_lb holds steady during a packet.
module tdma_route (
    input  logic       sel_lb,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    input  logic       in_sop,
    input  logic       in_eop,
    output logic       in_ready,
    output logic       tx_valid,
    output logic [7:0] tx_data,
    output logic       tx_sop,
    output logic       tx_eop,
    input  logic       tx_ready,
    output logic       lb_valid,
    output logic [7:0] lb_data,
    output logic       lb_sop,
    output logic       lb_eop,
    input  logic       lb_ready
);
    // Steer valid to one side and take ready from that same side.
    always_comb begin
        tx_valid = in_valid && !sel_lb;
        lb_valid = in_valid && sel_lb;
        tx_data  = in_data;
        lb_data  = in_data;
        tx_sop   = in_sop && !sel_lb;
        lb_sop   = in_sop && sel_lb;
        tx_eop   = in_eop && !sel_lb;
        lb_eop   = in_eop && sel_lb;
        in_ready = sel_lb ? lb_ready : tx_ready;
    end
endmodule

// File: rtl/tdma_engine.sv
// Descriptor-chain transmit DMA: walks descriptors in memory, streams
// packet bytes, writes consumed descriptors back, stops on an empty one.
// Assumes packet buffers are word aligned and ADDR_W <= 32.
module tdma_engine
    import tdma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_wr,
    input  logic [ADDR_W-1:0] base_wdata,
    input  logic              en_wr,
    input  logic              en_wdata,
    input  logic              mac_tx_en,
    input  logic              loop_en,
    output logic              dma_en,
    output logic              busy,
    output logic              sent_evt,
    output logic              underrun_evt,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_gnt,
    input  logic [31:0]       mem_rdata,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_sop,
    output logic              tx_eop,
    input  logic              tx_ready,
    output logic              lb_valid,
    output logic [7:0]        lb_data,
    output logic              lb_sop,
    output logic              lb_eop,
    input  logic              lb_ready
);
    localparam int BYTES = WORD_W / 8;
    localparam int NB_W  = $clog2(BYTES) + 1;
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(BYTES);

    tdma_state_e       st_q;
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] cur_q;
    logic [ADDR_W-1:0] bptr_q;
    logic [WORD_W-1:0] w0_q;
    logic [WORD_W-1:0] w1_q;
    logic [WORD_W-1:0] w2_q;
    logic [LEN_W-1:0]  rem_q;
    logic              first_q;
    logic              loop_q;
    logic              en_q;
    logic              sent_q;
    logic              und_q;

    logic [NB_W-1:0]   nb;
    logic [LEN_W-1:0]  len;
    logic              ser_load;
    logic              ser_idle;
    logic              s_valid;
    logic [7:0]        s_data;
    logic              s_sop;
    logic              s_eop;
    logic              s_ready;

    // Base register: keeps a word-aligned copy of the written address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
        end else if (base_wr) begin
            base_q <= {base_wdata[ADDR_W-1:2], 2'b00};
        end
    end

    // Lane count for the next buffer word and the length field.
    always_comb begin
        nb       = (rem_q >= LEN_W'(BYTES)) ? NB_W'(BYTES) : NB_W'(rem_q);
        len      = w1_q[LEN_W-1:0];
        ser_load = (st_q == ST_RD) && mem_gnt;
    end

    // Chain walker: fetch, check, stream, write back, follow the next pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            cur_q   <= '0;
            bptr_q  <= '0;
            w0_q    <= '0;
            w1_q    <= '0;
            w2_q    <= '0;
            rem_q   <= '0;
            first_q <= 1'b0;
            loop_q  <= 1'b0;
            en_q    <= 1'b0;
            sent_q  <= 1'b0;
            und_q   <= 1'b0;
        end else begin
            sent_q <= 1'b0;
            und_q  <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (en_wr) begin
                        en_q <= en_wdata;
                        if (en_wdata && mac_tx_en) begin
                            cur_q  <= base_q;
                            loop_q <= loop_en;
                            st_q   <= ST_D0;
                        end
                    end
                end
                ST_D0: if (mem_gnt) begin w0_q <= mem_rdata; st_q <= ST_D1; end
                ST_D1: if (mem_gnt) begin w1_q <= mem_rdata; st_q <= ST_D2; end
                ST_D2: if (mem_gnt) begin w2_q <= mem_rdata; st_q <= ST_CHK; end
                ST_CHK: begin
                    if (w1_q[EMPTY_BIT]) begin
                        en_q  <= 1'b0;
                        und_q <= 1'b1;
                        st_q  <= ST_IDLE;
                    end else begin
                        rem_q   <= len;
                        bptr_q  <= ADDR_W'(w0_q);
                        first_q <= 1'b1;
                        st_q    <= (len == '0) ? ST_W0 : ST_RD;
                    end
                end
                ST_RD: begin
                    if (mem_gnt) begin
                        rem_q   <= rem_q - LEN_W'(nb);
                        bptr_q  <= bptr_q + STEP;
                        first_q <= 1'b0;
                        st_q    <= ST_TX;
                    end
                end
                ST_TX: if (ser_idle) st_q <= (rem_q == '0) ? ST_W0 : ST_RD;
                ST_W0: if (mem_gnt) st_q <= ST_W1;
                ST_W1: if (mem_gnt) st_q <= ST_W2;
                ST_W2: begin
                    if (mem_gnt) begin
                        sent_q <= 1'b1;
                        cur_q  <= ADDR_W'(w2_q);
                        st_q   <= ST_D0;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // Memory request decode: address, direction and write data per state.
    always_comb begin
        mem_req   = 1'b1;
        mem_we    = 1'b0;
        mem_addr  = cur_q;
        mem_wdata = '0;
        case (st_q)
            ST_D0:   mem_addr = cur_q;
            ST_D1:   mem_addr = cur_q + STEP;
            ST_D2:   mem_addr = cur_q + 2 * STEP;
            ST_RD:   mem_addr = bptr_q;
            ST_W0:   begin mem_we = 1'b1; mem_addr = cur_q;            mem_wdata = w0_q; end
            ST_W1:   begin mem_we = 1'b1; mem_addr = cur_q + STEP;     mem_wdata = w1_q | (32'd1 << EMPTY_BIT); end
            ST_W2:   begin mem_we = 1'b1; mem_addr = cur_q + 2 * STEP; mem_wdata = w2_q; end
            default: mem_req = 1'b0;
        endcase
    end

    // Status outputs.
    always_comb begin
        busy         = (st_q != ST_IDLE);
        dma_en       = en_q;
        sent_evt     = sent_q;
        underrun_evt = und_q;
    end

    tdma_byte_ser #(.WORD_W(WORD_W), .NB_W(NB_W)) u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (ser_load),
        .load_word (mem_rdata),
        .load_nb   (nb),
        .load_first(first_q),
        .load_last (rem_q == LEN_W'(nb)),
        .out_valid (s_valid),
        .out_data  (s_data),
        .out_sop   (s_sop),
        .out_eop   (s_eop),
        .out_ready (s_ready),
        .idle      (ser_idle)
    );

    tdma_route u_route (
        .sel_lb  (loop_q),
        .in_valid(s_valid),
        .in_data (s_data),
        .in_sop  (s_sop),
        .in_eop  (s_eop),
        .in_ready(s_ready),
        .tx_valid(tx_valid),
        .tx_data (tx_data),
        .tx_sop  (tx_sop),
        .tx_eop  (tx_eop),
        .tx_ready(tx_ready),
        .lb_valid(lb_valid),
        .lb_data (lb_data),
        .lb_sop  (lb_sop),
        .lb_eop  (lb_eop),
        .lb_ready(lb_ready)
    );

    // R4: an ungranted request holds its address and direction.
    a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    // R5: the end-of-chain event coincides with enable cleared and idle.
    a_r5_underrun_stop: assert property (@(posedge clk) disable iff (!rst_n)
        underrun_evt |-> !busy && !dma_en);

    // R11: the enable bit stays set for the whole walk.
    a_r11_busy_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> dma_en);

    // R9: a sent event follows a granted write-back.
    a_r9_sent_after_wb: assert property (@(posedge clk) disable iff (!rst_n)
        sent_evt |-> $past(mem_req && mem_we && mem_gnt));
endmodule

// File: tb/tdma_engine_test.sv
// Directed bench for the transmit DMA engine with a memory model and sinks.
module tdma_engine_test;
    localparam int CLK_P = 10;
    localparam int WATCHDOG = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        base_wr = 1'b0;
    logic [31:0] base_wdata = '0;
    logic        en_wr = 1'b0;
    logic        en_wdata = 1'b0;
    logic        mac_tx_en = 1'b0;
    logic        loop_en = 1'b0;
    logic        dma_en, busy, sent_evt, underrun_evt;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_gnt = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        tx_valid, tx_sop, tx_eop;
    logic [7:0]  tx_data;
    logic        tx_ready = 1'b0;
    logic        lb_valid, lb_sop, lb_eop;
    logic [7:0]  lb_data;
    logic        lb_ready = 1'b0;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int mem_lat = 0;
    bit stall = 0;
    int wctr = 0;

    logic [31:0] mem [512];
    logic [31:0] rlog [64];
    logic [31:0] wla [16];
    logic [31:0] wld [16];
    logic [7:0]  cap_d [64];
    logic        cap_s [64];
    logic        cap_e [64];
    logic [7:0]  exp_d [64];
    int rn, wn, tn, ln, sent_n, und_n;

    tdma_engine uut (
        .clk(clk), .rst_n(rst_n), .base_wr(base_wr), .base_wdata(base_wdata),
        .en_wr(en_wr), .en_wdata(en_wdata), .mac_tx_en(mac_tx_en), .loop_en(loop_en),
        .dma_en(dma_en), .busy(busy), .sent_evt(sent_evt), .underrun_evt(underrun_evt),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_sop(tx_sop), .tx_eop(tx_eop),
        .tx_ready(tx_ready),
        .lb_valid(lb_valid), .lb_data(lb_data), .lb_sop(lb_sop), .lb_eop(lb_eop),
        .lb_ready(lb_ready)
    );

    always #(CLK_P / 2) clk = ~clk;

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Watchdog: a hung run is counted as a failure.
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > WATCHDOG) begin
                errors++;
                checks++;
                $display("FAIL watchdog: cycles=%0d expected below %0d", cyc, WATCHDOG);
                finish_run();
            end
        end
    end

    // Memory responder, sinks and event monitors, all at the falling edge.
    initial begin
        forever begin
            @(negedge clk);
            mem_gnt = 1'b0;
            if (mem_req) begin
                if (wctr >= mem_lat) begin
                    mem_gnt = 1'b1;
                    wctr = 0;
                    if (mem_we) begin
                        mem[mem_addr[10:2]] = mem_wdata;
                        if (wn < 16) begin wla[wn] = mem_addr; wld[wn] = mem_wdata; end
                        wn++;
                    end else begin
                        mem_rdata = mem[mem_addr[10:2]];
                        if (rn < 64) rlog[rn] = mem_addr;
                        rn++;
                    end
                end else begin
                    wctr++;
                end
            end
            tx_ready = !(stall && (cyc % 3 == 0));
            lb_ready = !(stall && (cyc % 4 == 1));
            if (tx_valid && tx_ready) begin
                if (tn + ln < 64) begin
                    cap_d[tn + ln] = tx_data; cap_s[tn + ln] = tx_sop; cap_e[tn + ln] = tx_eop;
                end
                tn++;
            end
            if (lb_valid && lb_ready) begin
                if (tn + ln < 64) begin
                    cap_d[tn + ln] = lb_data; cap_s[tn + ln] = lb_sop; cap_e[tn + ln] = lb_eop;
                end
                ln++;
            end
            if (sent_evt) sent_n++;
            if (underrun_evt) und_n++;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic clear_logs();
        rn = 0; wn = 0; tn = 0; ln = 0; sent_n = 0; und_n = 0;
    endtask

    task automatic put_desc(input int a, input logic [31:0] b, input logic [31:0] sz,
                            input logic [31:0] nx);
        mem[a >> 2] = b;
        mem[(a >> 2) + 1] = sz;
        mem[(a >> 2) + 2] = nx;
    endtask

    // Fills a buffer with seed+3*i, padding the last word with 8'hEE.
    task automatic put_pkt(input int b, input int len, input int seed, input int eoff);
        int nw = (len + 3) / 4;
        for (int w = 0; w < nw; w++) begin
            logic [31:0] v = '0;
            for (int k = 0; k < 4; k++) begin
                int i = w * 4 + k;
                logic [7:0] by = (i < len) ? 8'(seed + 3 * i) : 8'hEE;
                v[k*8 +: 8] = by;
                if (i < len) exp_d[eoff + i] = by;
            end
            mem[(b >> 2) + w] = v;
        end
    endtask

    task automatic en_write(input logic v);
        @(negedge clk);
        en_wr = 1'b1; en_wdata = v;
        @(negedge clk);
        en_wr = 1'b0;
    endtask

    task automatic start_walk(input logic [31:0] base);
        @(negedge clk);
        base_wr = 1'b1; base_wdata = base;
        @(negedge clk);
        base_wr = 1'b0;
        en_write(1'b1);
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 5000) begin @(negedge clk); n++; end
        chk("R5 walk ends", {31'd0, busy}, 32'd0);
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 busy", {31'd0, busy}, 0);
        chk("R1 dma_en", {31'd0, dma_en}, 0);
        chk("R1 mem_req", {31'd0, mem_req}, 0);
        chk("R1 tx_valid", {31'd0, tx_valid}, 0);
        chk("R1 lb_valid", {31'd0, lb_valid}, 0);
        chk("R1 events", {30'd0, sent_evt, underrun_evt}, 0);
    endtask

    task automatic t_no_mac();
        clear_logs();
        mac_tx_en = 1'b0;
        en_write(1'b1);
        repeat (20) @(negedge clk);
        chk("R2 busy stays low", {31'd0, busy}, 0);
        chk("R2 no requests", rn + wn, 0);
        chk("R2 bit stored", {31'd0, dma_en}, 1);
        en_write(1'b0);
        chk("R2 bit cleared", {31'd0, dma_en}, 0);
        mac_tx_en = 1'b1;
    endtask

    task automatic t_single();
        clear_logs();
        put_desc(32'h100, 32'h200, 32'd6, 32'h140);
        put_desc(32'h140, 32'h0, 32'h8000_0000, 32'h0);
        put_pkt(32'h200, 6, 8'h10, 0);
        start_walk(32'h103);
        wait_idle();
        chk("R3 aligned first read", rlog[0], 32'h100);
        chk("R4 second read", rlog[1], 32'h104);
        chk("R4 third read", rlog[2], 32'h108);
        chk("R6 buffer word 0", rlog[3], 32'h200);
        chk("R6 buffer word 1", rlog[4], 32'h204);
        chk("R7 byte count", tn, 6);
        for (int i = 0; i < 6; i++) chk("R6 byte", {24'd0, cap_d[i]}, {24'd0, exp_d[i]});
        chk("R6 sop", {30'd0, cap_s[0], cap_s[1]}, 32'd2);
        chk("R7 eop", {30'd0, cap_e[4], cap_e[5]}, 32'd1);
        chk("R8 write count", wn, 3);
        chk("R8 wb addr 0", wla[0], 32'h100);
        chk("R8 wb addr", wla[1], 32'h104);
        chk("R8 wb buf", wld[0], 32'h200);
        chk("R8 wb size", wld[1], 32'h8000_0006);
        chk("R8 wb next", wld[2], 32'h140);
        chk("R9 next fetch", rlog[5], 32'h140);
        chk("R9 sent count", sent_n, 1);
        chk("R5 underrun count", und_n, 1);
        chk("R5 enable cleared", {31'd0, dma_en}, 0);
    endtask

    task automatic t_chain();
        clear_logs();
        stall = 1; mem_lat = 2;
        put_desc(32'h300, 32'h400, 32'd4, 32'h310);
        put_desc(32'h310, 32'h440, 32'd9, 32'h320);
        put_desc(32'h320, 32'h000, 32'd0, 32'h330);
        put_desc(32'h330, 32'h0, 32'h8000_0000, 32'h0);
        put_pkt(32'h400, 4, 8'h40, 0);
        put_pkt(32'h440, 9, 8'h81, 4);
        start_walk(32'h300);
        wait_idle();
        chk("R7 chain bytes", tn, 13);
        for (int i = 0; i < 13; i++) chk("R12 stalled byte", {24'd0, cap_d[i]}, {24'd0, exp_d[i]});
        chk("R6 sop positions", {30'd0, cap_s[0], cap_s[4]}, 32'd3);
        chk("R7 eop positions", {30'd0, cap_e[3], cap_e[12]}, 32'd3);
        chk("R13 zero-length consumed", mem[(32'h320 >> 2) + 1], 32'h8000_0000);
        chk("R13 sent count", sent_n, 3);
        chk("R5 underrun once", und_n, 1);
        stall = 0; mem_lat = 0;
    endtask

    task automatic t_loop();
        clear_logs();
        loop_en = 1'b1;
        put_desc(32'h500, 32'h600, 32'd5, 32'h510);
        put_desc(32'h510, 32'h0, 32'h8000_0000, 32'h0);
        put_pkt(32'h600, 5, 8'hA0, 0);
        start_walk(32'h500);
        loop_en = 1'b0;
        wait_idle();
        chk("R10 no tx bytes", tn, 0);
        chk("R10 loop bytes", ln, 5);
        for (int i = 0; i < 5; i++) chk("R10 loop byte", {24'd0, cap_d[i]}, {24'd0, exp_d[i]});
        chk("R10 loop markers", {30'd0, cap_s[0], cap_e[4]}, 32'd3);
    endtask

    task automatic t_busy_write();
        clear_logs();
        mem_lat = 4;
        put_desc(32'h700, 32'h680, 32'd8, 32'h710);
        put_desc(32'h710, 32'h6C0, 32'd8, 32'h720);
        put_desc(32'h720, 32'h0, 32'h8000_0000, 32'h0);
        put_pkt(32'h680, 8, 8'h05, 0);
        put_pkt(32'h6C0, 8, 8'h55, 8);
        start_walk(32'h700);
        repeat (6) @(negedge clk);
        en_write(1'b0);
        chk("R11 enable kept", {31'd0, dma_en}, 1);
        chk("R11 still busy", {31'd0, busy}, 1);
        repeat (10) @(negedge clk);
        en_write(1'b1);
        wait_idle();
        chk("R11 sent count", sent_n, 2);
        chk("R11 underrun once", und_n, 1);
        chk("R11 byte count", tn, 16);
        chk("R11 last byte", {24'd0, cap_d[15]}, {24'd0, exp_d[15]});
        mem_lat = 0;
    endtask

    task automatic t_empty_first();
        clear_logs();
        put_desc(32'h780, 32'h200, 32'h8000_0003, 32'h100);
        start_walk(32'h780);
        wait_idle();
        chk("R5 no bytes", tn + ln, 0);
        chk("R5 no write-back", wn, 0);
        chk("R5 no sent", sent_n, 0);
        chk("R5 underrun", und_n, 1);
        chk("R5 enable cleared", {31'd0, dma_en}, 0);
    endtask

    initial begin
        for (int i = 0; i < 512; i++) mem[i] = '0;
        clear_logs();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_no_mac();
        t_single();
        t_chain();
        t_loop();
        t_busy_write();
        t_empty_first();
        finish_run();
    end
endmodule